// File: doc/BRIEF.md
# Dual Prescaled Tick Generator

This block derives two independent count-enable strobes, A and B, from the master clock. Downstream PWM channel counters select one of them as their count clock. A single 32-bit configuration word holds one 16-bit field per generator. Inside a field, a 4-bit exponent chooses a power-of-two prescale and an 8-bit value sets a linear divider that follows it. Each output is a one-cycle tick that repeats every `2^p * d` master cycles.

A generator with an all-zero field is off and stays silent. An exponent above ten or a divider of zero also switches it off. When a write changes a generator's decoded setting, that generator's counters restart, so its first tick comes exactly one new period after the write. A write that leaves a generator's decoded setting unchanged does not disturb its phase, so software can rewrite the whole word to retune one generator without jolting the other.

Top module: `dual_rate_tick_gen`

## Requirements
- R1: Generator A takes its divider from `cfg_wdata[7:0]` and its exponent from `cfg_wdata[11:8]`. Generator B takes its divider from `cfg_wdata[23:16]` and its exponent from `cfg_wdata[27:24]`. The word is captured on a rising clock edge with `cfg_we` high.
- R2: With exponent p (0..10) and divider d (1..255), the generator ticks once every `2^p * d` master cycles. Each tick is a one-cycle high pulse on `tick_a` or `tick_b`. When `2^p * d` is 1, the output stays high on every cycle.
- R3: A generator whose field is all zero produces no ticks.
- R4: A generator whose exponent is greater than 10, or whose divider is 0, produces no ticks.
- R5: A write that changes a generator's decoded exponent or divider restarts it. Its output is low until the first new tick, which appears exactly `2^p * d` cycles after the write edge. No tick from the old setting appears.
- R6: Bits [15:12] and [31:28] are ignored. A write whose decoded exponent and divider equal the current ones leaves that generator's tick phase unchanged.
- R7: The two generators are independent. Writing a new value into one field does not shift the other generator's ticks.
- R8: While synchronous active-high `rst` is high, and on the first cycle after it, both outputs are low and both generators are off.
- R9: The boundary settings work: p=0, d=1 ticks on every cycle; p=10 with d=2 ticks every 2048 cycles; p=3 with d=255 ticks every 2040 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word, A field low half, B field high half |
| tick_a | output | 1 | One-cycle count enable from generator A |
| tick_b | output | 1 | One-cycle count enable from generator B |

## Verification
The assertions assume that the configuration word changes only on cycles where `cfg_we` is high. They also assume that an exponent or divider only takes effect through a write, so a live generator never sees its setting move without a restart. The stimulus drives `cfg_we` and `cfg_wdata` only between clock edges, and holds the data bus steady when no write is meant. The stimulus reaches every off condition and the same-value rewrite. It also makes mid-period retunes of one field while the other field runs, and the largest periods are kept short enough that several ticks fall inside each observation window.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int NUM_GEN  = 2;
    localparam int FIELD_W  = 16;
    localparam int DIV_W    = 8;
    localparam int PSEL_W   = 4;
    localparam int MAX_PSEL = 10;
    localparam int PCNT_W   = MAX_PSEL;
    localparam int WORD_W   = NUM_GEN * FIELD_W;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic [DIV_W-1:0]  div;
    } gen_cfg_t;

    function automatic gen_cfg_t field_decode(input logic [FIELD_W-1:0] f);
        gen_cfg_t r;
        r.psel = f[DIV_W +: PSEL_W];
        r.div  = f[DIV_W-1:0];
        return r;
    endfunction

    function automatic logic cfg_active(input gen_cfg_t c);
        return (c.div != '0) && (int'(c.psel) <= MAX_PSEL);
    endfunction

    function automatic logic [PCNT_W-1:0] tap_mask(input logic [PSEL_W-1:0] psel);
        logic [PCNT_W-1:0] m;
        m = '0;
        for (int i = 0; i < PCNT_W; i++) begin
            if (i < int'(psel)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/rtg_prescaler.sv
module rtg_prescaler
    import rtg_pkg::*;
#(
    parameter int CNT_W = PCNT_W,
    parameter int SEL_W = PSEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] psel,
    output logic             stb
);

    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] mask;

    assign mask = tap_mask(psel);
    assign stb  = run && ((pcnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr || !run) pcnt <= '0;
        else                    pcnt <= pcnt + 1'b1;
    end

    // R2: once the exponent is nonzero, a prescale strobe is never followed by another on the next cycle
    a_r2_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
        (run && !clr && stb && (psel != '0)) |=> !stb);

endmodule

// File: rtl/rtg_divider.sv
module rtg_divider
    import rtg_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         run,
    input  logic         stb,
    input  logic [W-1:0] div,
    output logic         tick
);

    logic [W-1:0] dcnt;
    logic [W-1:0] last;

    assign last = div - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            dcnt <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (stb) begin
                if (dcnt == last) begin
                    dcnt <= '0;
                    tick <= 1'b1;
                end else begin
                    dcnt <= dcnt + 1'b1;
                end
            end
        end
    end

    // R4: a live divider never counts beyond its programmed value
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (dcnt < div));

    // R2: with a divider above one, ticks never come back to back
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (run && !clr && tick && (div > 1)) |=> !tick);

endmodule

// File: rtl/rtg_channel.sv
module rtg_channel
    import rtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [FIELD_W-1:0] field,
    output logic               tick
);

    gen_cfg_t cfg_q;
    gen_cfg_t cfg_new;
    logic     chg;
    logic     run;
    logic     pre_stb;

    assign cfg_new = field_decode(field);
    assign chg     = we && (cfg_new != cfg_q);
    assign run     = cfg_active(cfg_q);

    always_ff @(posedge clk) begin
        if (rst)      cfg_q <= '0;
        else if (chg) cfg_q <= cfg_new;
    end

    rtg_prescaler #(.CNT_W(PCNT_W), .SEL_W(PSEL_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (chg),
        .run  (run),
        .psel (cfg_q.psel),
        .stb  (pre_stb)
    );

    rtg_divider #(.W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .clr  (chg),
        .run  (run),
        .stb  (pre_stb),
        .div  (cfg_q.div),
        .tick (tick)
    );

    // R3 and R4: a generator that is off stays silent
    a_r3_off_silent: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);

    // R5: the cycle after a restart carries no leftover tick
    a_r5_restart_quiet: assert property (@(posedge clk) disable iff (rst)
        chg |=> !tick);

    // R6: a rewrite with the same decoded setting keeps the setting
    a_r6_same_keeps: assert property (@(posedge clk) disable iff (rst)
        (we && !chg) |=> (cfg_q == $past(cfg_q)));

endmodule

// File: rtl/dual_rate_tick_gen.sv
module dual_rate_tick_gen
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              tick_a,
    output logic              tick_b
);

    logic [NUM_GEN-1:0] ticks;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        rtg_channel u_ch (
            .clk   (clk),
            .rst   (rst),
            .we    (cfg_we),
            .field (cfg_wdata[g*FIELD_W +: FIELD_W]),
            .tick  (ticks[g])
        );
    end

    assign tick_a = ticks[0];
    assign tick_b = ticks[1];

    // R8: both outputs are quiet on the cycle after reset
    a_r8_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!tick_a && !tick_b));

endmodule

// File: tb/tb_dual_rate_tick_gen.sv
`timescale 1ns/1ps
module tb_dual_rate_tick_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        tick_a;
    logic        tick_b;

    int checks = 0;
    int failures = 0;
    string cur_req = "R8";
    logic cmp_en = 1'b0;

    always #10 clk = ~clk;

    dual_rate_tick_gen dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tick_a(tick_a), .tick_b(tick_b)
    );

    // behavioural reference: per generator a period length and a cycle counter
    logic [11:0] m_f   [2];
    logic        m_act [2];
    int          m_per [2];
    int          m_cnt [2];
    logic        m_exp [2];

    always @(posedge clk) begin
        for (int g = 0; g < 2; g++) begin
            logic [11:0] f;
            int p, d;
            f = cfg_wdata[g*16 +: 12];
            if (rst) begin
                m_f[g] = '0; m_act[g] = 1'b0; m_per[g] = 0; m_cnt[g] = 0; m_exp[g] = 1'b0;
            end else if (cfg_we && (f != m_f[g])) begin
                m_f[g] = f;
                p = int'(f[11:8]);
                d = int'(f[7:0]);
                m_act[g] = (d != 0) && (p <= 10);
                m_per[g] = m_act[g] ? ((1 << p) * d) : 0;
                m_cnt[g] = 0;
                m_exp[g] = 1'b0;
            end else if (m_act[g]) begin
                m_cnt[g] = m_cnt[g] + 1;
                if (m_cnt[g] == m_per[g]) begin
                    m_exp[g] = 1'b1;
                    m_cnt[g] = 0;
                end else begin
                    m_exp[g] = 1'b0;
                end
            end else begin
                m_exp[g] = 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            check(cur_req, tick_a, m_exp[0], "tick_a vs model");
            check(cur_req, tick_b, m_exp[1], "tick_b vs model");
        end
    end

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic count_ticks(input int cycles, output int na, output int nb);
        na = 0; nb = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (tick_a) na++;
            if (tick_b) nb++;
        end
    endtask

    initial begin
        #(20 * 190000);
        failures++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int na, nb;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cmp_en = 1'b1;
        // R8: quiet after reset
        cur_req = "R8";
        count_ticks(20, na, nb);
        check_int("R8", na + nb, 0, "ticks after reset");

        // R1 R2: A p=2 d=3 -> period 12; B zero (R3)
        cur_req = "R2";
        write_cfg(32'h0000_0203);
        count_ticks(120, na, nb);
        check_int("R2", na, 10, "A ticks in 120 cycles at period 12");
        check_int("R3", nb, 0, "B ticks with zero field");

        // R1 R7: B p=1 d=5 -> period 10, A rewritten unchanged
        cur_req = "R7";
        repeat (5) @(negedge clk);
        write_cfg(32'h0105_0203);
        count_ticks(100, na, nb);
        check_int("R1", nb, 10, "B ticks in 100 cycles at period 10");

        // R6: ignored upper bits, same setting, phase kept
        cur_req = "R6";
        repeat (3) @(negedge clk);
        write_cfg(32'hF105_F203);
        count_ticks(60, na, nb);

        // R5: retune A mid-period to p=0 d=7
        cur_req = "R5";
        repeat (4) @(negedge clk);
        write_cfg(32'h0105_0007);
        count_ticks(6, na, nb);
        check_int("R5", na, 0, "A quiet before first new period");
        @(negedge clk);
        check("R5", tick_a, 1'b1, "A first tick at 7 cycles after write");

        // R9: every-cycle tick on A, p=10 d=2 on B
        cur_req = "R9";
        write_cfg(32'h0A02_0001);
        count_ticks(4100, na, nb);
        check_int("R9", na, 4100, "A ticks every cycle");
        check_int("R9", nb, 2, "B ticks at period 2048");
        write_cfg(32'h03FF_0001);
        count_ticks(4100, na, nb);
        check_int("R9", nb, 2, "B ticks at period 2040");

        // R4: exponent above ten, exponent 15, divider zero
        cur_req = "R4";
        write_cfg(32'h0300_0B05);
        count_ticks(3000, na, nb);
        check_int("R4", na, 0, "A with exponent 11");
        check_int("R4", nb, 0, "B with divider 0");
        write_cfg(32'h0300_0F01);
        count_ticks(100, na, nb);
        check_int("R4", na, 0, "A with exponent 15");

        // R3: switching a running generator off
        cur_req = "R3";
        write_cfg(32'h0000_0003);
        repeat (10) @(negedge clk);
        write_cfg(32'h0000_0000);
        count_ticks(50, na, nb);
        check_int("R3", na, 0, "A after field cleared");

        // R8: reset in the middle of activity
        cur_req = "R8";
        write_cfg(32'h0001_0001);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8", tick_a, 1'b0, "tick_a under reset");
        check("R8", tick_b, 1'b0, "tick_b under reset");
        rst = 1'b0;
        count_ticks(20, na, nb);
        check_int("R8", na + nb, 0, "ticks after mid-run reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule